// File: doc/BRIEF.md
# Interference Amplitude Sweep Sequencer

This block runs an accelerated error-ratio measurement of a serial link without an operator. It drives a 4-bit amplitude code to a binary-weighted current DAC that sets the strength of an injected interference tone. It also presents a route select, which picks the data channel or the decision-threshold channel, and a waveform select, which picks square or sine. While no run is active the interference is off and the code is zero.

After start, the block climbs from code 1. At each code it launches one measurement on an external pattern tester, which counts bits and errors. The tester ends a measurement once the error count passes a fixed limit of more than one hundred, or once a bit budget is used up. The first code at which errors exceed bits/2^k is the working point. From there the block steps down by one code per measurement until it reaches code 1 or a measurement times out. Each of these measurements writes the code, the bit count, the error count and the timeout flag into a result buffer. Software reads the buffer afterwards and fits a line to extrapolate to zero interference.

Top module: `sweep_amp_seq`

## Requirements
- R1: After reset and whenever no run is active, busy_o=0, inj_en_o=0 and dac_code_o=0.
- R2: A start_i pulse while idle sets busy_o=1, inj_en_o=1 and dac_code_o=1 at the next edge. tst_start_o is high for exactly one cycle per measurement.
- R3: During the upward search, a result with errors <= bits>>k (k = cfg_ratio_k_i, latched at start) records nothing. The next measurement then runs at the code plus one.
- R4: The first result with errors > bits>>k is recorded as entry 0. The next measurement then runs at the code minus one.
- R5: After the working point, every result is recorded, and each following measurement runs exactly one code lower.
- R6: The run ends after the entry for code 1 is written. busy_o, inj_en_o and dac_code_o then return to 0.
- R7: A result flagged by tst_tmo_i during the downward walk is recorded with its timeout bit set, and the run ends.
- R8: If code 15 is reached without exceeding the target, the result at code 15 is recorded as entry 0 and the downward walk begins.
- R9: abort_i returns the block to idle at the next edge from any state, with inj_en_o=0 and dac_code_o=0.
- R10: inj_path_o (0 data, 1 threshold) and inj_shape_o (0 square, 1 sine) hold the values of cfg_path_i and cfg_shape_i captured at start. They ignore input changes during the run.
- R11: tst_err_limit_o equals 101. tst_bit_limit_o holds the cfg_bit_limit_i captured at start.
- R12: count_o gives the number of entries written since the last start. rd_addr_i selects an entry returning code, bits, errors and timeout flag.
- R13: start_i while busy has no effect on the current code or the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a sweep |
| abort_i | input | 1 | Stop and disable interference |
| cfg_path_i | input | 1 | Route: 0 data, 1 threshold |
| cfg_shape_i | input | 1 | Shape: 0 square, 1 sine |
| cfg_ratio_k_i | input | 6 | Target ratio exponent k |
| cfg_bit_limit_i | input | 48 | Per-step bit budget |
| inj_en_o | output | 1 | Interference enable |
| inj_path_o | output | 1 | Latched route |
| inj_shape_o | output | 1 | Latched shape |
| dac_code_o | output | 4 | Amplitude DAC code |
| busy_o | output | 1 | Sweep in progress |
| tst_start_o | output | 1 | Launch one measurement |
| tst_err_limit_o | output | 32 | Error count that ends a measurement |
| tst_bit_limit_o | output | 48 | Bit budget for a measurement |
| tst_done_i | input | 1 | Measurement finished |
| tst_bits_i | input | 48 | Bits counted |
| tst_errs_i | input | 32 | Errors counted |
| tst_tmo_i | input | 1 | Bit budget ran out |
| rd_addr_i | input | 4 | Result entry index |
| rd_code_o | output | 4 | Stored code |
| rd_bits_o | output | 48 | Stored bit count |
| rd_errs_o | output | 32 | Stored error count |
| rd_tmo_o | output | 1 | Stored timeout flag |
| count_o | output | 5 | Entries written |

## Verification
The properties assume that the tester raises tst_done_i only while a launched measurement is pending, holds it for a single cycle, and never raises it in the cycle of its own launch. The bench tester model meets this. It answers every tst_start_o pulse with exactly one done pulse two cycles later. It drops abort_i and start_i after one cycle, and it only raises extra start pulses while waiting for a result. Its error counts sit at bits>>k for codes below a chosen threshold and one above it for codes at or past it, so every comparison falls on the boundary.

// File: rtl/sweep_pkg.sv
package sweep_pkg;
  parameter int CODE_W = 4;
  parameter int BITS_W = 48;
  parameter int ERRS_W = 32;
  parameter int K_W    = 6;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic [BITS_W-1:0] bits;
    logic [ERRS_W-1:0] errs;
    logic              tmo;
  } entry_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LAUNCH = 2'd1,
    ST_WAIT   = 2'd2
  } state_e;
endpackage

// File: rtl/sweep_ratio_cmp.sv
module sweep_ratio_cmp
  import sweep_pkg::*;
(
  input  logic [BITS_W-1:0] bits_i,
  input  logic [ERRS_W-1:0] errs_i,
  input  logic [K_W-1:0]    k_i,
  output logic              hit_o
);
  logic [BITS_W-1:0] thresh;
  logic [BITS_W-1:0] errs_ext;

  assign thresh   = bits_i >> k_i;
  assign errs_ext = BITS_W'(errs_i);
  assign hit_o    = errs_ext > thresh;
endmodule

// File: rtl/sweep_result_buf.sv
module sweep_result_buf
  import sweep_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          wr_en_i,
  input  entry_t        wr_entry_i,
  input  logic [AW-1:0] rd_addr_i,
  output entry_t        rd_entry_o,
  output logic [CW-1:0] count_o
);
  entry_t        ent_q [DEPTH];
  logic [CW-1:0] cnt_q;
  logic          wr_ok;

  assign wr_ok = wr_en_i && (cnt_q < CW'(DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (wr_ok)   cnt_q <= cnt_q + 1'b1;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          ent_q[g] <= '0;
      else if (wr_ok && cnt_q == CW'(g))    ent_q[g] <= wr_entry_i;
    end
  end

  assign rd_entry_o = ent_q[rd_addr_i];
  assign count_o    = cnt_q;
endmodule

// File: rtl/sweep_ctrl.sv
module sweep_ctrl
  import sweep_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic              done_i,
  input  logic              tmo_i,
  input  logic              hit_i,
  output logic              accept_o,
  output logic              active_o,
  output logic              launch_o,
  output logic              wr_en_o,
  output logic [CODE_W-1:0] code_o
);
  localparam logic [CODE_W-1:0] CODE_MAX = '1;
  localparam logic [CODE_W-1:0] CODE_MIN = CODE_W'(1);

  state_e            state_q;
  logic              walk_q;
  logic [CODE_W-1:0] code_q;
  logic              rec;
  logic              fin;

  assign accept_o = (state_q == ST_IDLE) && start_i && !abort_i;
  // record once past the working point, at the working point, or at the top code
  assign rec      = walk_q || hit_i || (code_q == CODE_MAX);
  assign fin      = (code_q == CODE_MIN) || tmo_i;
  assign wr_en_o  = (state_q == ST_WAIT) && done_i && rec && !abort_i;
  assign launch_o = (state_q == ST_LAUNCH);
  assign active_o = (state_q != ST_IDLE);
  assign code_o   = code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      walk_q  <= 1'b0;
      code_q  <= '0;
    end else if (abort_i) begin
      state_q <= ST_IDLE;
      walk_q  <= 1'b0;
      code_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_LAUNCH;
          walk_q  <= 1'b0;
          code_q  <= CODE_MIN;
        end
        ST_LAUNCH: state_q <= ST_WAIT;
        ST_WAIT: if (done_i) begin
          if (rec && fin) begin
            state_q <= ST_IDLE;
            walk_q  <= 1'b0;
            code_q  <= '0;
          end else if (rec) begin
            state_q <= ST_LAUNCH;
            walk_q  <= 1'b1;
            code_q  <= code_q - 1'b1;
          end else begin
            state_q <= ST_LAUNCH;
            code_q  <= code_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sweep_amp_seq.sv
module sweep_amp_seq
  import sweep_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int ERR_STOP = 101,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic              cfg_path_i,
  input  logic              cfg_shape_i,
  input  logic [K_W-1:0]    cfg_ratio_k_i,
  input  logic [BITS_W-1:0] cfg_bit_limit_i,
  output logic              inj_en_o,
  output logic              inj_path_o,
  output logic              inj_shape_o,
  output logic [CODE_W-1:0] dac_code_o,
  output logic              busy_o,
  output logic              tst_start_o,
  output logic [ERRS_W-1:0] tst_err_limit_o,
  output logic [BITS_W-1:0] tst_bit_limit_o,
  input  logic              tst_done_i,
  input  logic [BITS_W-1:0] tst_bits_i,
  input  logic [ERRS_W-1:0] tst_errs_i,
  input  logic              tst_tmo_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [CODE_W-1:0] rd_code_o,
  output logic [BITS_W-1:0] rd_bits_o,
  output logic [ERRS_W-1:0] rd_errs_o,
  output logic              rd_tmo_o,
  output logic [CW-1:0]     count_o
);
  logic              accept, active, launch, wr_en, hit;
  logic [CODE_W-1:0] code;
  logic              path_q, shape_q;
  logic [K_W-1:0]    k_q;
  logic [BITS_W-1:0] blim_q;
  entry_t            wr_entry, rd_entry;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      path_q  <= 1'b0;
      shape_q <= 1'b0;
      k_q     <= '0;
      blim_q  <= '0;
    end else if (accept) begin
      path_q  <= cfg_path_i;
      shape_q <= cfg_shape_i;
      k_q     <= cfg_ratio_k_i;
      blim_q  <= cfg_bit_limit_i;
    end
  end

  sweep_ratio_cmp u_cmp (
    .bits_i (tst_bits_i),
    .errs_i (tst_errs_i),
    .k_i    (k_q),
    .hit_o  (hit)
  );

  sweep_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .abort_i  (abort_i),
    .done_i   (tst_done_i),
    .tmo_i    (tst_tmo_i),
    .hit_i    (hit),
    .accept_o (accept),
    .active_o (active),
    .launch_o (launch),
    .wr_en_o  (wr_en),
    .code_o   (code)
  );

  assign wr_entry = '{code: code, bits: tst_bits_i, errs: tst_errs_i, tmo: tst_tmo_i};

  sweep_result_buf #(.DEPTH(DEPTH)) u_buf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (accept),
    .wr_en_i    (wr_en),
    .wr_entry_i (wr_entry),
    .rd_addr_i  (rd_addr_i),
    .rd_entry_o (rd_entry),
    .count_o    (count_o)
  );

  assign inj_en_o        = active;
  assign busy_o          = active;
  assign inj_path_o      = path_q;
  assign inj_shape_o     = shape_q;
  assign dac_code_o      = code;
  assign tst_start_o     = launch;
  assign tst_err_limit_o = ERRS_W'(ERR_STOP);
  assign tst_bit_limit_o = blim_q;
  assign rd_code_o       = rd_entry.code;
  assign rd_bits_o       = rd_entry.bits;
  assign rd_errs_o       = rd_entry.errs;
  assign rd_tmo_o        = rd_entry.tmo;
endmodule

// File: rtl/sweep_amp_seq_chk.sv
module sweep_amp_seq_chk
  import sweep_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              abort_i,
  input logic              tst_done_i,
  input logic              busy_o,
  input logic              inj_en_o,
  input logic              inj_path_o,
  input logic              inj_shape_o,
  input logic              tst_start_o,
  input logic [CODE_W-1:0] dac_code_o
);
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!inj_en_o && dac_code_o == '0));

  a_r2_start_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && !abort_i) |=> (busy_o && dac_code_o == CODE_W'(1)));

  a_r2_single_launch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tst_start_o |=> !tst_start_o);

  // R3 and R5: code moves by exactly one step while a run continues
  a_r5_unit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && dac_code_o != $past(dac_code_o)) |->
      (dac_code_o == $past(dac_code_o) + 1'b1 || dac_code_o == $past(dac_code_o) - 1'b1));

  a_r9_abort_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (!busy_o && !inj_en_o && dac_code_o == '0));

  a_r10_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(inj_path_o) && $stable(inj_shape_o)));

  a_r13_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !tst_done_i && !abort_i) |=> $stable(dac_code_o));
endmodule

bind sweep_amp_seq sweep_amp_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .abort_i     (abort_i),
  .tst_done_i  (tst_done_i),
  .busy_o      (busy_o),
  .inj_en_o    (inj_en_o),
  .inj_path_o  (inj_path_o),
  .inj_shape_o (inj_shape_o),
  .tst_start_o (tst_start_o),
  .dac_code_o  (dac_code_o)
);

// File: tb/sim_sweep_amp_seq.sv
`timescale 1ns/1ps
module sim_sweep_amp_seq;
  localparam longint BITS = 64'd1048576;
  localparam int NROW = 5;
  // k, first code exceeding target (16 = never), walk timeout code (0 = none)
  localparam int TBL [NROW][3] = '{
    '{6, 5, 0},
    '{10, 1, 0},
    '{4, 16, 0},
    '{8, 9, 4},
    '{3, 12, 11}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, abort_i = 1'b0;
  logic        cfg_path = 1'b0, cfg_shape = 1'b0;
  logic [5:0]  cfg_k = '0;
  logic [47:0] cfg_blim = '0;
  logic        tst_done = 1'b0, tst_tmo = 1'b0;
  logic [47:0] tst_bits = '0;
  logic [31:0] tst_errs = '0;
  logic [3:0]  rd_addr = '0;
  logic        inj_en, inj_path, inj_shape, busy, tst_start, rd_tmo;
  logic [3:0]  dac, rd_code;
  logic [31:0] err_lim, rd_errs;
  logic [47:0] bit_lim, rd_bits;
  logic [4:0]  count;

  int n_chk = 0, n_fail = 0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  sweep_amp_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .abort_i(abort_i),
    .cfg_path_i(cfg_path), .cfg_shape_i(cfg_shape), .cfg_ratio_k_i(cfg_k),
    .cfg_bit_limit_i(cfg_blim), .inj_en_o(inj_en), .inj_path_o(inj_path),
    .inj_shape_o(inj_shape), .dac_code_o(dac), .busy_o(busy),
    .tst_start_o(tst_start), .tst_err_limit_o(err_lim), .tst_bit_limit_o(bit_lim),
    .tst_done_i(tst_done), .tst_bits_i(tst_bits), .tst_errs_i(tst_errs),
    .tst_tmo_i(tst_tmo), .rd_addr_i(rd_addr), .rd_code_o(rd_code),
    .rd_bits_o(rd_bits), .rd_errs_o(rd_errs), .rd_tmo_o(rd_tmo), .count_o(count)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_row(input int k, input int hit, input int tmo);
    int exp_c, c, start_c, stop_c, cnt, guard;
    bit walk, rec, t;
    longint base;
    base = BITS >> k;
    @(negedge clk); cfg_k = 6'(k); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    chk(busy && inj_en && dac == 4'd1, "R2 start", {busy, inj_en, dac}, 6'b110001);
    chk(count == 0, "R12 count cleared", count, 0);
    exp_c = 1; walk = 0; guard = 0;
    while (busy && guard < 400) begin
      guard++;
      if (tst_start) begin
        chk(dac == 4'(exp_c), walk ? "R5 walk code" : "R3 search code", dac, exp_c);
        c = exp_c;
        rec = walk || c >= hit || c == 15;
        t = walk && c == tmo;
        repeat (2) @(negedge clk);
        tst_bits = BITS; tst_errs = 32'(base + ((c >= hit) ? 1 : 0));
        tst_tmo = t; tst_done = 1'b1;
        @(negedge clk); tst_done = 1'b0; tst_tmo = 1'b0;
        if (rec) begin
          walk = 1;
          exp_c = (c == 1 || t) ? 0 : c - 1;
        end else exp_c = c + 1;
      end else @(negedge clk);
    end
    chk(!busy && !inj_en && dac == 0, "R6 end idle", {busy, inj_en, dac}, 0);
    start_c = (hit > 15) ? 15 : hit;
    stop_c = (tmo > 0) ? tmo : 1;
    cnt = start_c - stop_c + 1;
    chk(count == 5'(cnt), "R12 count", count, cnt);
    for (int i = 0; i < cnt; i++) begin
      rd_addr = 4'(i); #1;
      chk(rd_code == 4'(start_c - i), (i == 0) ? ((hit > 15) ? "R8 first code" : "R4 first code") : "R5 entry code",
          rd_code, start_c - i);
      chk(rd_errs == 32'(base + ((start_c - i >= hit) ? 1 : 0)), "R12 errs", rd_errs,
          base + ((start_c - i >= hit) ? 1 : 0));
      chk(rd_bits == BITS, "R12 bits", rd_bits, BITS);
      chk(rd_tmo == (tmo != 0 && i == cnt - 1), "R7 tmo flag", rd_tmo, (tmo != 0 && i == cnt - 1));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !inj_en && dac == 0 && !tst_start, "R1 reset", {busy, inj_en, dac}, 0);
    chk(count == 0, "R12 reset count", count, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !inj_en && dac == 0, "R1 after reset", {busy, inj_en, dac}, 0);

    for (int r = 0; r < NROW; r++) run_row(TBL[r][0], TBL[r][1], TBL[r][2]);

    // R10, R11, R13, R9: directed run
    @(negedge clk);
    cfg_path = 1'b1; cfg_shape = 1'b1; cfg_blim = 48'd12345; cfg_k = 6'd2; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    cfg_path = 1'b0; cfg_shape = 1'b0; cfg_blim = 48'd7;
    chk(inj_path && inj_shape, "R10 latched cfg", {inj_path, inj_shape}, 3);
    chk(err_lim == 32'd101, "R11 err limit", err_lim, 101);
    chk(bit_lim == 48'd12345, "R11 bit limit", bit_lim, 12345);
    @(negedge clk);
    chk(inj_path && inj_shape, "R10 hold cfg", {inj_path, inj_shape}, 3);
    start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    chk(busy && dac == 4'd1, "R13 start ignored", dac, 1);
    abort_i = 1'b1;
    @(negedge clk); abort_i = 1'b0;
    chk(!busy && !inj_en && dac == 0, "R9 abort", {busy, inj_en, dac}, 0);
    tst_bits = BITS; tst_errs = 32'hFFFF; tst_done = 1'b1;
    @(negedge clk); tst_done = 1'b0;
    @(negedge clk);
    chk(!busy && dac == 0 && count == 0, "R9 stray done ignored", {busy, dac, count}, 0);

    done_flag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      n_chk++; n_fail++;
      $display("FAIL R6 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule